// File: doc/BRIEF.md
# Configurable Polarity Host Bus Adapter

This block connects an external processor bus to an internal 16-bit word interface. Each host access arrives as a single-cycle strobe. The strobe comes with a read/write line, a byte-select line, a memory/register select, an address and write data. The block turns each access into a word request on one of two internal ports, one for memory and one for registers. It raises a ready pulse when the host side of the access is done. A busy output stays high while a word request is outstanding, and the host waits for ready before it issues the next strobe.

Three strap pins are captured while reset is held. The width strap picks the 16-bit buffered mode or the 8-bit buffered mode. The polarity strap sets the sense of the read/write line in 16-bit mode and the sense of the byte-select line in 8-bit mode. The order strap says which byte of a pair comes first.

In 8-bit mode a pair sequencer handles the bytes. For writes it stages the first byte and merges it with the second into one word write. For reads it fetches the word on the first byte and serves the second byte from a latched copy. If the host breaks the expected byte sequence, the sequencer starts over and sets a sticky error flag.

Top module: `hba_top`

## Requirements
- R1: The width, polarity and order straps are captured on every clock edge while rst_n is low and are held unchanged after reset is released. Changing the strap pins later has no effect until the next reset.
- R2: In 16-bit mode with polarity strap 1, host_rw=1 is a read and host_rw=0 is a write. With polarity strap 0 the sense is reversed: host_rw=0 is a read and host_rw=1 is a write.
- R3: host_mem_sel=1 sends the word request to the memory port (mem_*). host_mem_sel=0 sends it to the register port (reg_*).
- R4: A 16-bit access raises its word request on the clock edge after the strobe. The request holds its direction, address and data until it is acknowledged. host_ready pulses one cycle after the acknowledge, and read data is on host_rdata while host_ready is high.
- R5: In 8-bit mode a byte access targets the most significant byte when host_bsel XOR polarity strap is 1, and the least significant byte otherwise. So with polarity 0, a high host_bsel selects the MSB.
- R6: In 8-bit mode, order strap 1 means MSB then LSB and order strap 0 means LSB then MSB, for reads and writes alike. In 16-bit mode the order strap and host_bsel have no effect.
- R7: In 8-bit mode a first write byte (host_wdata[7:0]) is staged, host_ready pulses on the next cycle, and no word request is made. The second write byte causes exactly one word write that carries each byte in its own lane, using the first byte's address and target.
- R8: In 8-bit mode a first read byte fetches the whole word and returns the selected byte on host_rdata[7:0], with host_rdata[15:8]=0. The second read byte is returned from the latched word one cycle after its strobe, with no word request.
- R9: In 8-bit mode a byte that is not the next one expected under the order strap, or a second byte whose direction differs from the first, is dropped. It makes no word request, host_ready pulses on the next cycle, the sequencer returns to expecting a first byte, and host_seq_err is set and stays set until reset.
- R10: In 8-bit mode host_rw=1 is a read and host_rw=0 is a write, whatever the polarity strap.
- R11: While reset is held, host_ready, host_busy, host_seq_err, mem_req and reg_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the strap capture window |
| strap_wide | input | 1 | 1 selects 16-bit mode, 0 selects 8-bit mode |
| strap_pol | input | 1 | Polarity strap for the read/write or byte-select sense |
| strap_order | input | 1 | 1 means MSB first, 0 means LSB first |
| host_strb | input | 1 | One-cycle access strobe |
| host_rw | input | 1 | Read/write line, sense set by mode and strap |
| host_bsel | input | 1 | Byte select line (8-bit mode) |
| host_mem_sel | input | 1 | 1 selects memory, 0 selects registers |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data; only the low byte is used in 8-bit mode |
| host_rdata | output | DATA_W | Read data, valid while host_ready is high |
| host_ready | output | 1 | Access-complete pulse |
| host_busy | output | 1 | A word request is outstanding |
| host_seq_err | output | 1 | Sticky byte-sequence error |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | ADDR_W | Memory port address |
| mem_wdata | output | DATA_W | Memory port write word |
| mem_rdata | input | DATA_W | Memory port read word |
| mem_ack | input | 1 | Memory port acknowledge |
| reg_req | output | 1 | Register port request |
| reg_we | output | 1 | Register port write enable |
| reg_addr | output | ADDR_W | Register port address |
| reg_wdata | output | DATA_W | Register port write word |
| reg_rdata | input | DATA_W | Register port read word |
| reg_ack | input | 1 | Register port acknowledge |

## Verification
A word request appears one cycle after the strobe that causes it. Accesses that make no word request (a staged write byte, a latched read byte, or a dropped out-of-sequence byte) complete with host_ready one cycle after the strobe. Accesses that do make a word request complete with host_ready one cycle after the acknowledge. The bench's port model acknowledges one cycle after it sees the request. Because of these varying latencies, the driver queues the expected word transactions and host completions before each strobe, and it checks separately that the request is present on the first falling edge after the strobe. Monitors on the falling edge compare each acknowledged word transfer and each ready pulse with the head of its queue. Any transfer that arrives with nothing queued counts as a failure, so an unwanted word request is caught.

// File: rtl/hba_pkg.sv
// Package: shared types for the host bus adapter.
// Assumes a single clock domain; the word request carries no data fields here.
package hba_pkg;
    typedef enum logic {
        TGT_REG = 1'b0,
        TGT_MEM = 1'b1
    } hba_tgt_e;

    typedef struct packed {
        logic     valid;
        logic     we;
        hba_tgt_e tgt;
    } hba_wreq_t;
endpackage

// File: rtl/hba_strap_decode.sv
// Module: captures the straps during reset and decodes the host
// read/write and byte-select lines. Assumes the straps are static while rst_n is low.
module hba_strap_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_wide,
    input  logic strap_pol,
    input  logic strap_order,
    input  logic host_rw,
    input  logic host_bsel,
    output logic wide,
    output logic msb_first,
    output logic is_read,
    output logic is_msb
);
    logic pol_q;

    // Strap capture: follows the pins during reset, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide      <= strap_wide;
            pol_q     <= strap_pol;
            msb_first <= strap_order;
        end
    end

    // Line decode: polarity applies to rw in 16-bit mode and to bsel in 8-bit mode.
    always_comb begin
        is_read = wide ? ~(host_rw ^ pol_q) : host_rw;
        is_msb  = host_bsel ^ pol_q;
    end

    assert_straps_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(wide) && $stable(pol_q) && $stable(msb_first)));
endmodule

// File: rtl/hba_pair_seq.sv
// Module: access sequencer. In 16-bit mode each strobe becomes a word
// request. In 8-bit mode it pairs bytes, staging writes and latching reads.
// Assumes the host waits for ready before the next strobe.
module hba_pair_seq
    import hba_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              msb_first,
    input  logic              strb,
    input  logic              is_read,
    input  logic              is_msb,
    input  logic              mem_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              word_ack,
    input  logic [DATA_W-1:0] word_rdata,
    output hba_wreq_t         wreq,
    output logic [ADDR_W-1:0] wreq_addr,
    output logic [DATA_W-1:0] wreq_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              seq_err
);
    localparam int BYTE_W = DATA_W / 2;

    logic              phase_q;
    logic              pair_we_q;
    hba_tgt_e          pair_tgt_q;
    logic [ADDR_W-1:0] pair_addr_q;
    logic [BYTE_W-1:0] stage_q;
    logic [DATA_W-1:0] latch_q;
    logic              pend_msb_q;
    logic              first_ok;
    logic              second_ok;

    // Sequence check: first byte must match the order, second the other byte and same direction.
    always_comb begin
        first_ok  = (is_msb == msb_first);
        second_ok = (is_msb != msb_first) && (is_read != pair_we_q);
    end

    // Main sequencer: request issue, completion, byte staging and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wreq        <= '0;
            wreq_addr   <= '0;
            wreq_wdata  <= '0;
            rdata       <= '0;
            ready       <= 1'b0;
            seq_err     <= 1'b0;
            phase_q     <= 1'b0;
            pair_we_q   <= 1'b0;
            pair_tgt_q  <= TGT_REG;
            pair_addr_q <= '0;
            stage_q     <= '0;
            latch_q     <= '0;
            pend_msb_q  <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (wreq.valid) begin
                if (word_ack) begin
                    wreq.valid <= 1'b0;
                    ready      <= 1'b1;
                    if (!wreq.we) begin
                        if (wide) begin
                            rdata <= word_rdata;
                        end else begin
                            latch_q <= word_rdata;
                            rdata   <= {{BYTE_W{1'b0}},
                                        pend_msb_q ? word_rdata[DATA_W-1:BYTE_W]
                                                   : word_rdata[BYTE_W-1:0]};
                        end
                    end
                end
            end else if (strb) begin
                if (wide) begin
                    wreq       <= '{valid: 1'b1, we: !is_read, tgt: hba_tgt_e'(mem_sel)};
                    wreq_addr  <= addr;
                    wreq_wdata <= wdata;
                end else if (!phase_q) begin
                    pair_we_q   <= !is_read;
                    pair_tgt_q  <= hba_tgt_e'(mem_sel);
                    pair_addr_q <= addr;
                    if (!first_ok) begin
                        seq_err <= 1'b1;
                        ready   <= 1'b1;
                    end else if (!is_read) begin
                        phase_q <= 1'b1;
                        stage_q <= wdata[BYTE_W-1:0];
                        ready   <= 1'b1;
                    end else begin
                        phase_q    <= 1'b1;
                        pend_msb_q <= is_msb;
                        wreq       <= '{valid: 1'b1, we: 1'b0, tgt: hba_tgt_e'(mem_sel)};
                        wreq_addr  <= addr;
                    end
                end else begin
                    phase_q <= 1'b0;
                    if (!second_ok) begin
                        seq_err <= 1'b1;
                        ready   <= 1'b1;
                    end else if (pair_we_q) begin
                        wreq       <= '{valid: 1'b1, we: 1'b1, tgt: pair_tgt_q};
                        wreq_addr  <= pair_addr_q;
                        wreq_wdata <= msb_first ? {stage_q, wdata[BYTE_W-1:0]}
                                                : {wdata[BYTE_W-1:0], stage_q};
                    end else begin
                        rdata <= {{BYTE_W{1'b0}},
                                  is_msb ? latch_q[DATA_W-1:BYTE_W] : latch_q[BYTE_W-1:0]};
                        ready <= 1'b1;
                    end
                end
            end
        end
    end

    assert_ready_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !wreq.valid);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);
    assert_no_pair_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> !phase_q);
endmodule

// File: rtl/hba_word_router.sv
// Module: steers the single word request to the memory or register port
// and returns the acknowledge and read word from the chosen port.
// Assumes a port acknowledges only while its request is high.
module hba_word_router
    import hba_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hba_wreq_t         wreq,
    input  logic [ADDR_W-1:0] wreq_addr,
    input  logic [DATA_W-1:0] wreq_wdata,
    output logic              word_ack,
    output logic [DATA_W-1:0] word_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_ack
);
    // Port steering: one request line per target, shared address and data.
    always_comb begin
        mem_req    = wreq.valid && (wreq.tgt == TGT_MEM);
        reg_req    = wreq.valid && (wreq.tgt == TGT_REG);
        mem_we     = wreq.we;
        reg_we     = wreq.we;
        mem_addr   = wreq_addr;
        reg_addr   = wreq_addr;
        mem_wdata  = wreq_wdata;
        reg_wdata  = wreq_wdata;
        word_ack   = (wreq.tgt == TGT_MEM) ? mem_ack : reg_ack;
        word_rdata = (wreq.tgt == TGT_MEM) ? mem_rdata : reg_rdata;
    end

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
    assert_reg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));
endmodule

// File: rtl/hba_top.sv
// Module: top of the host bus adapter; wires strap decode, pair sequencer
// and word router. Assumes one strobe per access and that the host waits for ready.
module hba_top
    import hba_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_wide,
    input  logic              strap_pol,
    input  logic              strap_order,
    input  logic              host_strb,
    input  logic              host_rw,
    input  logic              host_bsel,
    input  logic              host_mem_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              host_busy,
    output logic              host_seq_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_ack
);
    logic              wide;
    logic              msb_first;
    logic              is_read;
    logic              is_msb;
    hba_wreq_t         wreq;
    logic [ADDR_W-1:0] wreq_addr;
    logic [DATA_W-1:0] wreq_wdata;
    logic              word_ack;
    logic [DATA_W-1:0] word_rdata;

    hba_strap_decode u_straps (
        .clk(clk), .rst_n(rst_n),
        .strap_wide(strap_wide), .strap_pol(strap_pol), .strap_order(strap_order),
        .host_rw(host_rw), .host_bsel(host_bsel),
        .wide(wide), .msb_first(msb_first), .is_read(is_read), .is_msb(is_msb)
    );

    hba_pair_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wide(wide), .msb_first(msb_first),
        .strb(host_strb), .is_read(is_read), .is_msb(is_msb), .mem_sel(host_mem_sel),
        .addr(host_addr), .wdata(host_wdata),
        .word_ack(word_ack), .word_rdata(word_rdata),
        .wreq(wreq), .wreq_addr(wreq_addr), .wreq_wdata(wreq_wdata),
        .rdata(host_rdata), .ready(host_ready), .seq_err(host_seq_err)
    );

    hba_word_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_router (
        .clk(clk), .rst_n(rst_n),
        .wreq(wreq), .wreq_addr(wreq_addr), .wreq_wdata(wreq_wdata),
        .word_ack(word_ack), .word_rdata(word_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ack(reg_ack)
    );

    // Busy output: a word request is outstanding.
    always_comb host_busy = wreq.valid;
endmodule

// File: tb/hba_top_tb.sv
module hba_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_wide = 1'b1, strap_pol = 1'b1, strap_order = 1'b0;
    logic host_strb = 1'b0, host_rw = 1'b0, host_bsel = 1'b0, host_mem_sel = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic host_ready, host_busy, host_seq_err;
    logic mem_req, mem_we, reg_req, reg_we;
    logic [ADDR_W-1:0] mem_addr, reg_addr;
    logic [DATA_W-1:0] mem_wdata, reg_wdata, mem_rdata, reg_rdata;
    logic mem_ack, reg_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard queues
    logic              ew_tgt[$];
    logic              ew_we[$];
    logic [ADDR_W-1:0] ew_addr[$];
    logic [DATA_W-1:0] ew_data[$];
    string             ew_tag[$];
    logic              eh_chk[$];
    logic [DATA_W-1:0] eh_data[$];
    string             eh_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hba_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .strap_wide(strap_wide), .strap_pol(strap_pol), .strap_order(strap_order),
        .host_strb(host_strb), .host_rw(host_rw), .host_bsel(host_bsel),
        .host_mem_sel(host_mem_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .host_busy(host_busy),
        .host_seq_err(host_seq_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ack(reg_ack)
    );

    function automatic logic [DATA_W-1:0] model(input logic tgt, input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] w;
        w = {{(DATA_W-ADDR_W){1'b0}}, a};
        return tgt ? (w * 16'd37 + 16'h1357) : (16'hBEEF ^ w);
    endfunction

    // Port models: acknowledge one cycle after a request is seen
    assign mem_rdata = model(1'b1, mem_addr);
    assign reg_rdata = model(1'b0, reg_addr);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            reg_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            reg_ack <= reg_req && !reg_ack;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Word-port monitor
    always @(negedge clk) begin
        if (rst_n && ((mem_req && mem_ack) || (reg_req && reg_ack))) begin
            logic t;
            t = mem_req;
            if (ew_tgt.size() == 0) begin
                chk(1'b0, "R7/R8/R9", "unexpected word request addr", int'(t ? mem_addr : reg_addr), 0);
            end else begin
                logic et, ewe;
                logic [ADDR_W-1:0] ea;
                logic [DATA_W-1:0] ed;
                string tg;
                et = ew_tgt.pop_front(); ewe = ew_we.pop_front();
                ea = ew_addr.pop_front(); ed = ew_data.pop_front(); tg = ew_tag.pop_front();
                chk(t == et, tg, "target", int'(t), int'(et));
                chk((t ? mem_we : reg_we) == ewe, tg, "write enable", int'(t ? mem_we : reg_we), int'(ewe));
                chk((t ? mem_addr : reg_addr) == ea, tg, "address", int'(t ? mem_addr : reg_addr), int'(ea));
                if (ewe)
                    chk((t ? mem_wdata : reg_wdata) == ed, tg, "write word", int'(t ? mem_wdata : reg_wdata), int'(ed));
            end
        end
    end

    // Host-completion monitor
    always @(negedge clk) begin
        if (rst_n && host_ready) begin
            if (eh_chk.size() == 0) begin
                chk(1'b0, "R4", "unexpected ready", 1, 0);
            end else begin
                logic c;
                logic [DATA_W-1:0] d;
                string tg;
                c = eh_chk.pop_front(); d = eh_data.pop_front(); tg = eh_tag.pop_front();
                if (c) chk(host_rdata == d, tg, "host read data", int'(host_rdata), int'(d));
            end
        end
    end

    // Driver: queue expectations, strobe once, wait for ready
    task automatic acc(input logic rw, input logic bsel, input logic msel,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input bit exp_word, input bit exp_we, input logic [ADDR_W-1:0] exp_a,
                       input logic [DATA_W-1:0] exp_wd, input bit chk_rd,
                       input logic [DATA_W-1:0] exp_rd, input string tag);
        if (exp_word) begin
            ew_tgt.push_back(msel); ew_we.push_back(exp_we); ew_addr.push_back(exp_a);
            ew_data.push_back(exp_wd); ew_tag.push_back(tag);
        end
        eh_chk.push_back(chk_rd); eh_data.push_back(exp_rd); eh_tag.push_back(tag);
        @(negedge clk);
        host_strb = 1'b1; host_rw = rw; host_bsel = bsel; host_mem_sel = msel;
        host_addr = a; host_wdata = wd;
        @(negedge clk);
        host_strb = 1'b0;
        if (exp_word)
            chk((mem_req | reg_req) == 1'b1, {tag, " R4"}, "request one cycle after strobe",
                int'(mem_req | reg_req), 1);
        else
            chk((mem_req | reg_req) == 1'b0, tag, "no word request", int'(mem_req | reg_req), 0);
        while (!host_ready) @(negedge clk);
    endtask

    task automatic do_reset(input logic w, input logic p, input logic o);
        @(negedge clk);
        rst_n = 1'b0;
        strap_wide = w; strap_pol = p; strap_order = o;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(host_ready == 1'b0, "R11", "ready in reset", int'(host_ready), 0);
        chk(host_busy == 1'b0, "R11", "busy in reset", int'(host_busy), 0);
        chk(host_seq_err == 1'b0, "R11", "seq_err in reset", int'(host_seq_err), 0);
        chk((mem_req | reg_req) == 1'b0, "R11", "request in reset", int'(mem_req | reg_req), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // 16-bit mode, polarity 1: rw high = read (R2)
        do_reset(1'b1, 1'b1, 1'b0);
        acc(1'b0, 1'b0, 1'b1, 12'h005, 16'h1234, 1, 1, 12'h005, 16'h1234, 0, '0, "R2 R3 mem write");
        acc(1'b1, 1'b0, 1'b0, 12'h009, 16'h0000, 1, 0, 12'h009, '0, 1, model(1'b0, 12'h009), "R2 R3 R4 reg read");
        acc(1'b1, 1'b1, 1'b1, 12'h0A0, 16'h0000, 1, 0, 12'h0A0, '0, 1, model(1'b1, 12'h0A0), "R3 R4 mem read");
        // 16-bit mode, polarity 0, order 1: rw low = read; bsel and order ignored (R2, R6)
        do_reset(1'b1, 1'b0, 1'b1);
        acc(1'b0, 1'b1, 1'b0, 12'h033, 16'h0000, 1, 0, 12'h033, '0, 1, model(1'b0, 12'h033), "R2 R6 reg read");
        acc(1'b1, 1'b0, 1'b1, 12'h044, 16'hCAFE, 1, 1, 12'h044, 16'hCAFE, 0, '0, "R2 R6 mem write");
        acc(1'b1, 1'b1, 1'b1, 12'h045, 16'hF00D, 1, 1, 12'h045, 16'hF00D, 0, '0, "R6 mem write bsel high");
        // 8-bit mode, polarity 0, MSB first: bsel high = MSB, rw high = read (R5, R10)
        do_reset(1'b0, 1'b0, 1'b1);
        acc(1'b0, 1'b1, 1'b1, 12'h003, 16'h00AB, 0, 0, '0, '0, 0, '0, "R7 stage MSB");
        acc(1'b0, 1'b0, 1'b1, 12'h003, 16'h00CD, 1, 1, 12'h003, 16'hABCD, 0, '0, "R5 R7 merged write");
        acc(1'b1, 1'b1, 1'b0, 12'h004, 16'h0000, 1, 0, 12'h004, '0, 1, {8'h00, model(1'b0, 12'h004)[15:8]}, "R8 R10 read MSB");
        acc(1'b1, 1'b0, 1'b0, 12'h004, 16'h0000, 0, 0, '0, '0, 1, {8'h00, model(1'b0, 12'h004)[7:0]}, "R8 read LSB latched");
        // R1: strap pins change without reset; 8-bit MSB-first behaviour stays
        @(negedge clk);
        strap_wide = 1'b1; strap_pol = 1'b1; strap_order = 1'b0;
        acc(1'b0, 1'b1, 1'b0, 12'h011, 16'h0012, 0, 0, '0, '0, 0, '0, "R1 stage after strap change");
        acc(1'b0, 1'b0, 1'b0, 12'h011, 16'h0034, 1, 1, 12'h011, 16'h1234, 0, '0, "R1 merged write");
        // R9: LSB offered first under MSB-first order
        chk(host_seq_err == 1'b0, "R9", "seq_err before fault", int'(host_seq_err), 0);
        acc(1'b0, 1'b0, 1'b1, 12'h020, 16'h0077, 0, 0, '0, '0, 0, '0, "R9 wrong first byte");
        chk(host_seq_err == 1'b1, "R9", "seq_err after fault", int'(host_seq_err), 1);
        // 8-bit mode, polarity 1, LSB first: bsel high = LSB (R5, R6)
        do_reset(1'b0, 1'b1, 1'b0);
        chk(host_seq_err == 1'b0, "R9", "seq_err cleared by reset", int'(host_seq_err), 0);
        acc(1'b0, 1'b1, 1'b1, 12'h030, 16'h0011, 0, 0, '0, '0, 0, '0, "R6 stage LSB");
        acc(1'b0, 1'b0, 1'b1, 12'h030, 16'h0022, 1, 1, 12'h030, 16'h2211, 0, '0, "R5 R6 R7 LSB-first write");
        acc(1'b1, 1'b1, 1'b1, 12'h007, 16'h0000, 1, 0, 12'h007, '0, 1, {8'h00, model(1'b1, 12'h007)[7:0]}, "R8 R10 read LSB first");
        acc(1'b0, 1'b0, 1'b1, 12'h007, 16'h0099, 0, 0, '0, '0, 0, '0, "R9 direction change");
        chk(host_seq_err == 1'b1, "R9", "seq_err after direction change", int'(host_seq_err), 1);
        acc(1'b0, 1'b1, 1'b0, 12'h050, 16'h0056, 0, 0, '0, '0, 0, '0, "R9 fresh pair stage");
        acc(1'b0, 1'b0, 1'b0, 12'h050, 16'h0078, 1, 1, 12'h050, 16'h7856, 0, '0, "R9 fresh pair write");
        chk(host_seq_err == 1'b1, "R9", "seq_err sticky", int'(host_seq_err), 1);
        repeat (3) @(negedge clk);
        chk(ew_tgt.size() == 0, "R7", "word queue drained", ew_tgt.size(), 0);
        chk(eh_chk.size() == 0, "R4", "host queue drained", eh_chk.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule